// File: doc/BRIEF.md
# SD Host Selective Software Reset

This block is the software reset control byte of an SD/eMMC host controller. Software writes one of three request bits over a small register bus. The block turns each request into a reset strobe for one domain: the data path (which also covers the DMA engine), the command path, or the whole controller. Each strobe clears only the state that belongs to its domain.

The block also holds a small model register file that the strobes act on. It has two present-state bytes, a block-gap control byte, a normal interrupt status byte, a host control byte and a data-buffer pointer. The line-level and card-detect byte is never touched by a software reset.

The partial reset bits last for a single cycle. The full-reset bit stays set until an internal capability-load model reports valid, `CAP_LAT` cycles after the full reset starts. Reads are registered: the read data shows the addressed register as it was at the clock edge that samples the address.

Top module: `sdh_srst_top`

## Requirements
- R1: After the synchronous reset `rst`, every register reads 0x00 and the three strobes `rst_all_o`, `rst_cmd_o` and `rst_dat_o` are low.
- R2: The reset register is at address 0x2F. Bit 0 requests the full reset, bit 1 the command reset and bit 2 the data reset. Bits 7:3 always read 0, and writing 0 to a bit requests nothing.
- R3: The data reset clears these bits and no others:
  - bits 6:1 of 0x20 (6 buffer-read-enable, 5 buffer-write-enable, 4 read-active, 3 write-active, 2 data-line-active, 1 inhibit-data);
  - bits 1:0 of 0x22 (1 continue-request, 0 stop-at-gap-request);
  - bits 5:1 of 0x23 (5 buffer-read-ready, 4 buffer-write-ready, 3 DMA interrupt, 2 block-gap event, 1 transfer-complete);
  - all of the buffer pointer at 0x25.
- R4: The command reset clears only bit 0 of 0x20 (inhibit-command) and bit 0 of 0x23 (command-complete).
- R5: The full reset clears 0x20, 0x22, 0x23, 0x24 and 0x25 entirely. The card/line byte at 0x21 (bit 0 command level, 1 data level, 2 write-protect level, 3 card-detect level, 4 card-stable, 5 card-inserted) is kept.
- R6: After a write with bit 0 set, `rst_all_o` and register bit 0 stay 1 for exactly `CAP_LAT` cycles (default 4), then clear by hardware.
- R7: A data or command request raises its strobe for exactly the one cycle after the write, and the bit then reads back as 0.
- R8: When bit 0 is written together with other request bits, only the full reset runs: `rst_dat_o` and `rst_cmd_o` stay low. Partial requests written while a full reset is running are dropped.
- R9: While a strobe is active, a bus write to any register that this strobe clears is ignored. Writes to other registers proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write enable for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data of the addressed register |
| rst_all_o | output | 1 | Full-controller reset strobe |
| rst_cmd_o | output | 1 | Command-path reset strobe |
| rst_dat_o | output | 1 | Data-path and DMA reset strobe |

## Verification
The main stimulus fills each model register with all ones (or a marker pattern) and then issues data-only, command-only, data-plus-command and all-three requests. The readback tells the three clear masks apart bit by bit, shows that both partial masks combine, and shows that the full reset dominates. Directed sequences time each strobe against the write edge and show that the full reset holds for its whole latency. They also place register writes inside the strobe cycle, both to cleared registers (the write must vanish) and to untouched ones (the write must land). Writes to the card/line byte during a full reset confirm that this byte survives.

// File: rtl/sdh_srst_pkg.sv
package sdh_srst_pkg;
  localparam int          NREG     = 6;
  localparam logic [7:0]  REG_BASE = 8'h20;
  localparam logic [7:0]  SRR_ADDR = 8'h2F;

  // register index: 0 pstate low, 1 card/line, 2 gap ctl, 3 int status,
  // 4 host ctl, 5 buffer pointer
  localparam logic [NREG-1:0][7:0] MASK_ALL = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF};
  localparam logic [NREG-1:0][7:0] MASK_DAT = {8'hFF, 8'h00, 8'h3E, 8'h03, 8'h00, 8'h7E};
  localparam logic [NREG-1:0][7:0] MASK_CMD = {8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01};
endpackage

// File: rtl/sdh_srst_req.sv
module sdh_srst_req #(
  parameter int CAP_LAT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_wr,
  input  logic [2:0] req_bits,
  output logic [2:0] req_q
);
  localparam int CNT_W = $clog2(CAP_LAT + 1);

  logic [CNT_W-1:0] cap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      cap_cnt <= '0;
    end else begin
      req_q[2:1] <= 2'b00;
      if (req_q[0]) begin
        if (cap_cnt == CNT_W'(CAP_LAT - 1)) req_q[0] <= 1'b0;
        else                               cap_cnt  <= cap_cnt + 1'b1;
      end
      if (req_wr) begin
        if (req_bits[0]) begin
          req_q[0] <= 1'b1;
          cap_cnt  <= '0;
        end else if (!req_q[0]) begin
          req_q[2:1] <= req_bits[2:1];
        end
      end
    end
  end
endmodule

// File: rtl/sdh_srst_regs.sv
module sdh_srst_regs
  import sdh_srst_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  input  logic                 clr_all,
  input  logic                 clr_cmd,
  input  logic                 clr_dat,
  output logic [NREG-1:0][7:0] regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic       hit;
    logic       blocked;
    logic [7:0] clr;
    logic [7:0] nxt;

    assign hit     = wr && (addr == REG_BASE + 8'(i));
    assign blocked = (clr_all && (MASK_ALL[i] != 8'h00)) ||
                     (clr_cmd && (MASK_CMD[i] != 8'h00)) ||
                     (clr_dat && (MASK_DAT[i] != 8'h00));
    assign clr     = (clr_all ? MASK_ALL[i] : 8'h00) |
                     (clr_cmd ? MASK_CMD[i] : 8'h00) |
                     (clr_dat ? MASK_DAT[i] : 8'h00);
    assign nxt     = (hit && !blocked) ? wdata : regs[i];

    always_ff @(posedge clk) begin
      if (rst) regs[i] <= 8'h00;
      else     regs[i] <= nxt & ~clr;
    end
  end
endmodule

// File: rtl/sdh_srst_top.sv
module sdh_srst_top
  import sdh_srst_pkg::*;
#(
  parameter int CAP_LAT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_all_o,
  output logic       rst_cmd_o,
  output logic       rst_dat_o
);
  logic [2:0]           req_q;
  logic [NREG-1:0][7:0] regs;
  logic [7:0]           rd_mux;

  sdh_srst_req #(.CAP_LAT(CAP_LAT)) u_req (
    .clk      (clk),
    .rst      (rst),
    .req_wr   (bus_wr && (bus_addr == SRR_ADDR)),
    .req_bits (bus_wdata[2:0]),
    .req_q    (req_q)
  );

  sdh_srst_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .clr_all (req_q[0]),
    .clr_cmd (req_q[1]),
    .clr_dat (req_q[2]),
    .regs    (regs)
  );

  assign rst_all_o = req_q[0];
  assign rst_cmd_o = req_q[1];
  assign rst_dat_o = req_q[2];

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == SRR_ADDR) rd_mux = {5'b0, req_q};
    for (int i = 0; i < NREG; i++)
      if (bus_addr == REG_BASE + 8'(i)) rd_mux = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sdh_srst_chk.sv
module sdh_srst_chk
  import sdh_srst_pkg::*;
#(
  parameter int CAP_LAT = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [7:0]           bus_addr,
  input logic                 bus_wr,
  input logic [7:0]           bus_wdata,
  input logic                 rst_all_o,
  input logic                 rst_cmd_o,
  input logic                 rst_dat_o,
  input logic [NREG-1:0][7:0] regs
);
  logic [15:0] run;
  logic        restart;
  assign restart = bus_wr && (bus_addr == SRR_ADDR) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst)          run <= '0;
    else if (restart) run <= '0;
    else if (rst_all_o) run <= run + 1'b1;
    else              run <= '0;
  end

  p_dat_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_dat_o |=> !rst_dat_o);
  p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_cmd_o |=> !rst_cmd_o);
  p_full_excl_r8: assert property (@(posedge clk) disable iff (rst)
    rst_all_o |-> (!rst_dat_o && !rst_cmd_o));
  p_dat_clear_r3: assert property (@(posedge clk) disable iff (rst)
    rst_dat_o |=> ((regs[0] & 8'h7E) == 8'h00) && ((regs[2] & 8'h03) == 8'h00)
                  && ((regs[3] & 8'h3E) == 8'h00) && (regs[5] == 8'h00));
  p_cmd_clear_r4: assert property (@(posedge clk) disable iff (rst)
    rst_cmd_o |=> (regs[0][0] == 1'b0) && (regs[3][0] == 1'b0));
  p_card_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (rst_all_o && !(bus_wr && bus_addr == REG_BASE + 8'd1)) |=> $stable(regs[1]));
  p_full_len_r6: assert property (@(posedge clk) disable iff (rst)
    rst_all_o |-> (run < 16'(CAP_LAT)));
  p_full_end_r6: assert property (@(posedge clk) disable iff (rst)
    (rst_all_o && run == 16'(CAP_LAT - 1) && !restart) |=> !rst_all_o);
endmodule

bind sdh_srst_top sdh_srst_chk #(.CAP_LAT(CAP_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .rst_all_o (rst_all_o),
  .rst_cmd_o (rst_cmd_o),
  .rst_dat_o (rst_dat_o),
  .regs      (regs)
);

// File: tb/sdh_srst_top_tb.sv
`timescale 1ns/1ps
module sdh_srst_top_tb;
  localparam int CAP = 4;
  localparam logic [7:0] SRR = 8'h2F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rst_all_o, rst_cmd_o, rst_dat_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sdh_srst_top #(.CAP_LAT(CAP)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_all_o(rst_all_o), .rst_cmd_o(rst_cmd_o), .rst_dat_o(rst_dat_o)
  );

  // {addr, write data, request byte, expected readback}
  localparam logic [31:0] VEC [18] = '{
    32'h20FF0481, 32'h20FF02FE, 32'h20FF0100,
    32'h213F013F, 32'h213F043F,
    32'h22070404, 32'h22070207, 32'h22070100,
    32'h23FF04C1, 32'h23FF02FE, 32'h23FF0100,
    32'h245A045A, 32'h245A025A, 32'h245A0100,
    32'h25330400, 32'h25330233,
    32'h20FF0680, 32'h23FF0700
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 strobes", {5'b0, rst_all_o, rst_cmd_o, rst_dat_o}, 8'h00);
    for (int a = 8'h20; a <= 8'h25; a++) begin
      rd(8'(a), v);
      chk("R1 reg", v, 8'h00);
    end
    rd(SRR, v);
    chk("R1 srr", v, 8'h00);

    // R3 R4 R5 R8: table of fills and requests
    for (int i = 0; i < 18; i++) begin
      wr(VEC[i][31:24], VEC[i][23:16]);
      wr(SRR, VEC[i][15:8]);
      idle(CAP + 3);
      rd(VEC[i][31:24], v);
      chk("R3/R4/R5/R8 table", v, VEC[i][7:0]);
      rd(SRR, v);
      chk("R6/R7 srr idle", v, 8'h00);
    end

    // R7: data strobe lasts one cycle, then reads 0
    wr(SRR, 8'h04);
    chk("R7 dat high", {7'b0, rst_dat_o}, 8'h01);
    @(negedge clk);
    chk("R7 dat low", {7'b0, rst_dat_o}, 8'h00);
    rd(SRR, v);
    chk("R7 dat bit reads 0", v, 8'h00);
    wr(SRR, 8'h02);
    chk("R7 cmd high", {7'b0, rst_cmd_o}, 8'h01);
    @(negedge clk);
    chk("R7 cmd low", {7'b0, rst_cmd_o}, 8'h00);

    // R6: full reset held CAP cycles, bit 0 reads 1 meanwhile
    wr(SRR, 8'h01);
    chk("R6 all high 0", {7'b0, rst_all_o}, 8'h01);
    rd(SRR, v);
    chk("R6 bit0 reads 1", v, 8'h01);
    for (int k = 2; k < CAP; k++) begin
      @(negedge clk);
      chk("R6 all still high", {7'b0, rst_all_o}, 8'h01);
    end
    @(negedge clk);
    chk("R6 all cleared", {7'b0, rst_all_o}, 8'h00);

    // R2: bits 7:3 inert and read 0; zero bits request nothing
    wr(SRR, 8'hF8);
    chk("R2 no strobe", {5'b0, rst_all_o, rst_cmd_o, rst_dat_o}, 8'h00);
    rd(SRR, v);
    chk("R2 reserved read 0", v, 8'h00);
    wr(SRR, 8'hF9);
    rd(SRR, v);
    chk("R2 only bit0", v, 8'h01);
    idle(CAP + 2);

    // R8: all three together runs only the full reset
    wr(SRR, 8'h07);
    chk("R8 priority", {5'b0, rst_all_o, rst_cmd_o, rst_dat_o}, 8'h04);
    wr(SRR, 8'h06);
    chk("R8 partial dropped", {5'b0, rst_all_o, rst_cmd_o, rst_dat_o}, 8'h04);
    idle(CAP + 2);
    chk("R8 no late partial", {5'b0, rst_all_o, rst_cmd_o, rst_dat_o}, 8'h00);

    // R9: writes during a strobe
    wr(SRR, 8'h04);
    wr(8'h23, 8'hFF);
    idle(2);
    rd(8'h23, v);
    chk("R9 dat blocks status write", v, 8'h00);
    wr(SRR, 8'h04);
    wr(8'h24, 8'h3C);
    idle(2);
    rd(8'h24, v);
    chk("R9 dat passes host write", v, 8'h3C);
    wr(SRR, 8'h02);
    wr(8'h20, 8'hFF);
    idle(2);
    rd(8'h20, v);
    chk("R9 cmd blocks pstate write", v, 8'h00);
    wr(SRR, 8'h02);
    wr(8'h22, 8'h05);
    idle(2);
    rd(8'h22, v);
    chk("R9 cmd passes gap write", v, 8'h05);
    wr(SRR, 8'h01);
    wr(8'h21, 8'hA5);
    idle(CAP + 2);
    rd(8'h21, v);
    chk("R9/R5 card byte write during full", v, 8'hA5);

    // R1: synchronous reset clears everything again
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd(8'h21, v);
    chk("R1 rst clears card byte", v, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule